// File: doc/BRIEF.md
# Quad-IO Serial Flash Target Responder

This block sits on the device side of a four-line serial flash link and answers as a small flash memory would. The host lowers chip select, toggles the serial clock and moves every phase four bits at a time on the IO lines. Those phases are an opcode byte, a start address and, for a program, the data bytes. The block decodes the opcode and gathers an address whose length depends on the opcode and on an address-width setting. It then either stores incoming bytes at consecutive locations or returns stored bytes at consecutive locations until chip select rises.

A write-enable latch guards programming. Programming can only clear bits, as flash cells do. The two configuration settings are plain inputs, and the write-enable latch and the program-overflow flag are visible as outputs. The serial clock, chip select and IO inputs are registered once in the system clock domain. Edges of the serial clock are found there, so the serial clock must run at least four times slower than the system clock.

Top module: `qspi_tgt`

## Requirements
- R1: After reset, io_oe, wel and ovf are 0 and every memory byte reads as 0xFF.
- R2: The opcode is taken from two nibbles, upper nibble first, on rising serial clock edges. Opcode 0x06 sets wel.
- R3: Address length in nibbles: opcodes 0x02 and 0xEB take 6 nibbles when cfg_addr4 is 0 and 8 when it is 1. Opcodes 0x12, 0x0C and 0xEC always take 8. The address is sent most significant nibble first, and only its low MEM_AW bits select a byte.
- R4: A program opcode (0x02 or 0x12) received while wel is 0 is ignored until chip select rises, and memory is unchanged.
- R5: Program data bytes arrive upper nibble first and go to consecutive addresses from the start address. Each stored byte becomes old AND new.
- R6: One program burst stores at most 256 bytes, or 512 when cfg_bigbuf is 1. Bytes past that limit are dropped and ovf is set. ovf is cleared when the next program opcode is accepted.
- R7: For read opcodes 0xEB, 0x0C and 0xEC, io_oe is 1 after the address. The upper nibble of the start byte is driven after the falling edge that follows the last address nibble. Each later falling edge gives the next nibble, upper before lower, from consecutive addresses.
- R8: The read address wraps from the top of the internal memory to 0.
- R9: Chip select high at any point aborts the command. A partly received data byte is discarded, and the next low period starts again at the opcode.
- R10: wel is cleared when chip select rises after an accepted program opcode.
- R11: Any other opcode is ignored: io_oe stays 0 and memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Chip select, active low |
| io_in | input | 4 | IO lines as seen from the host |
| io_out | output | 4 | Read data nibble |
| io_oe | output | 1 | Enable for driving io_out onto the IO lines |
| cfg_addr4 | input | 1 | Address-width setting (1 = four address bytes) |
| cfg_bigbuf | input | 1 | Large program buffer setting (1 = 512-byte limit) |
| wel | output | 1 | Write-enable latch |
| ovf | output | 1 | Program burst overflow flag |

## Verification
A rising or falling serial clock edge takes effect two system clocks later: one cycle for the input register and one for the edge-detect and state update. A read nibble is therefore valid on io_out two cycles after sck falls. The bench keeps every serial clock half period at four system clocks and samples io_out on a falling system clock edge just before it raises sck. It samples wel and ovf only after chip select has been high for several cycles. All expected bytes come from a bench-side memory model that applies the AND rule, the burst limit and the address wrap.

// File: rtl/qspi_tgt_pkg.sv
package qspi_tgt_pkg;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_PP     = 8'h02;
    localparam logic [7:0] OP_PP4    = 8'h12;
    localparam logic [7:0] OP_RD_CFG = 8'hEB;
    localparam logic [7:0] OP_RD4A   = 8'h0C;
    localparam logic [7:0] OP_RD4B   = 8'hEC;

    typedef struct packed {
        logic       rise;
        logic       fall;
        logic       active;
        logic [3:0] nib;
    } link_s;

    function automatic logic is_prog(input logic [7:0] op);
        return (op == OP_PP) || (op == OP_PP4);
    endfunction

    function automatic logic is_read(input logic [7:0] op);
        return (op == OP_RD_CFG) || (op == OP_RD4A) || (op == OP_RD4B);
    endfunction

    function automatic logic [3:0] addr_nibbles(input logic [7:0] op, input logic addr4);
        if ((op == OP_PP) || (op == OP_RD_CFG))
            return addr4 ? 4'd8 : 4'd6;
        return 4'd8;
    endfunction

endpackage

// File: rtl/qspi_tgt_front.sv
module qspi_tgt_front
    import qspi_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [3:0] io_in,
    output link_s      link
);

    logic       sck_q;
    logic       sck_d;
    logic       cs_q;
    logic [3:0] io_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sck_d <= 1'b0;
            cs_q  <= 1'b1;
            io_q  <= 4'h0;
        end else begin
            sck_q <= sck;
            sck_d <= sck_q;
            cs_q  <= cs_n;
            io_q  <= io_in;
        end
    end

    always_comb begin
        link.active = ~cs_q;
        link.rise   = sck_q & ~sck_d & ~cs_q;
        link.fall   = ~sck_q & sck_d & ~cs_q;
        link.nib    = io_q;
    end

endmodule

// File: rtl/qspi_tgt_mem.sv
module qspi_tgt_mem #(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= 8'hFF;
            end
        end else if (we) begin
            store[addr] <= store[addr] & wdata;
        end
    end

    assign rdata = store[addr];

    // R5: a program write can only turn ones into zeros
    a_r5_bits_only_clear: assert property (@(posedge clk) disable iff (rst)
        we |=> ((store[$past(addr)] & ~$past(store[addr])) == 8'h00));

endmodule

// File: rtl/qspi_tgt_ctrl.sv
module qspi_tgt_ctrl
    import qspi_tgt_pkg::*;
#(
    parameter int MEM_AW     = 6,
    parameter int PAGE_BYTES = 256,
    parameter int BIG_BYTES  = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  link_s             link,
    input  logic              cfg_addr4,
    input  logic              cfg_bigbuf,
    input  logic [7:0]        rd_data,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [3:0]        io_out,
    output logic              io_oe,
    output logic              wel,
    output logic              ovf
);

    localparam int CNT_W = $clog2(BIG_BYTES) + 1;

    phase_e            phase;
    logic [3:0]        nib_cnt;
    logic [3:0]        addr_len;
    logic [3:0]        opc_hi;
    logic [7:0]        op;
    logic [31:0]       addr_sh;
    logic [31:0]       addr_next;
    logic [MEM_AW-1:0] cur_addr;
    logic [3:0]        byte_hi;
    logic              hi_done;
    logic              rd_lo;
    logic [CNT_W-1:0]  burst_cnt;
    logic [CNT_W-1:0]  limit;
    logic [7:0]        opc_full;
    logic              room;

    assign limit     = cfg_bigbuf ? CNT_W'(BIG_BYTES) : CNT_W'(PAGE_BYTES);
    assign room      = burst_cnt < limit;
    assign addr_next = {addr_sh[27:0], link.nib};
    assign opc_full  = {opc_hi, link.nib};

    assign mem_we    = link.rise && (phase == PH_WDATA) && hi_done && room;
    assign mem_addr  = cur_addr;
    assign mem_wdata = {byte_hi, link.nib};
    assign io_oe     = (phase == PH_RDATA) && link.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_OPC;
            nib_cnt   <= 4'd0;
            addr_len  <= 4'd6;
            opc_hi    <= 4'h0;
            op        <= 8'h00;
            addr_sh   <= 32'h0;
            cur_addr  <= '0;
            byte_hi   <= 4'h0;
            hi_done   <= 1'b0;
            rd_lo     <= 1'b0;
            burst_cnt <= '0;
            io_out    <= 4'h0;
            wel       <= 1'b0;
            ovf       <= 1'b0;
        end else if (!link.active) begin
            if (is_prog(op) && ((phase == PH_ADDR) || (phase == PH_WDATA))) begin
                wel <= 1'b0;
            end
            phase   <= PH_OPC;
            nib_cnt <= 4'd0;
            hi_done <= 1'b0;
            rd_lo   <= 1'b0;
        end else begin
            unique case (phase)
                PH_OPC: if (link.rise) begin
                    if (nib_cnt == 4'd0) begin
                        opc_hi  <= link.nib;
                        nib_cnt <= 4'd1;
                    end else begin
                        op       <= opc_full;
                        nib_cnt  <= 4'd0;
                        addr_len <= addr_nibbles(opc_full, cfg_addr4);
                        addr_sh  <= 32'h0;
                        if (opc_full == OP_WREN) begin
                            wel   <= 1'b1;
                            phase <= PH_SKIP;
                        end else if (is_prog(opc_full)) begin
                            if (wel) begin
                                phase     <= PH_ADDR;
                                ovf       <= 1'b0;
                                burst_cnt <= '0;
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end else if (is_read(opc_full)) begin
                            phase <= PH_ADDR;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR: if (link.rise) begin
                    addr_sh <= addr_next;
                    nib_cnt <= nib_cnt + 4'd1;
                    if (nib_cnt == addr_len - 4'd1) begin
                        cur_addr <= addr_next[MEM_AW-1:0];
                        nib_cnt  <= 4'd0;
                        hi_done  <= 1'b0;
                        rd_lo    <= 1'b0;
                        phase    <= is_read(op) ? PH_RDATA : PH_WDATA;
                    end
                end
                PH_WDATA: if (link.rise) begin
                    if (!hi_done) begin
                        byte_hi <= link.nib;
                        hi_done <= 1'b1;
                    end else begin
                        hi_done <= 1'b0;
                        if (room) begin
                            burst_cnt <= burst_cnt + 1'b1;
                            cur_addr  <= cur_addr + 1'b1;
                        end else begin
                            ovf <= 1'b1;
                        end
                    end
                end
                PH_RDATA: if (link.fall) begin
                    io_out <= rd_lo ? rd_data[3:0] : rd_data[7:4];
                    rd_lo  <= ~rd_lo;
                    if (rd_lo) begin
                        cur_addr <= cur_addr + 1'b1;
                    end
                end
                PH_SKIP: ;
                default: phase <= PH_OPC;
            endcase
        end
    end

    // R2: write-enable opcode sets the latch
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (rst)
        (link.active && link.rise && (phase == PH_OPC) && (nib_cnt == 4'd1)
         && (opc_full == OP_WREN)) |=> wel);

    // R4: no memory write without the latch
    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wel);

    // R6: a byte past the limit raises the flag
    a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (link.active && link.rise && (phase == PH_WDATA) && hi_done && !room) |=> ovf);

    // R8: read address wraps to zero
    a_r8_read_wrap: assert property (@(posedge clk) disable iff (rst)
        (link.active && link.fall && (phase == PH_RDATA) && rd_lo && (cur_addr == '1))
        |=> (cur_addr == '0));

    // R9: chip select high returns to the opcode phase
    a_r9_cs_abort: assert property (@(posedge clk) disable iff (rst)
        !link.active |=> (phase == PH_OPC));

    // R10: end of a program transaction drops the latch
    a_r10_wel_clear: assert property (@(posedge clk) disable iff (rst)
        (!link.active && is_prog(op) && ((phase == PH_ADDR) || (phase == PH_WDATA)))
        |=> !wel);

endmodule

// File: rtl/qspi_tgt.sv
module qspi_tgt
    import qspi_tgt_pkg::*;
#(
    parameter int MEM_AW     = 6,
    parameter int PAGE_BYTES = 256,
    parameter int BIG_BYTES  = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic       io_oe,
    input  logic       cfg_addr4,
    input  logic       cfg_bigbuf,
    output logic       wel,
    output logic       ovf
);

    link_s             link;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;

    qspi_tgt_front u_front (
        .clk   (clk),
        .rst   (rst),
        .sck   (sck),
        .cs_n  (cs_n),
        .io_in (io_in),
        .link  (link)
    );

    qspi_tgt_ctrl #(
        .MEM_AW     (MEM_AW),
        .PAGE_BYTES (PAGE_BYTES),
        .BIG_BYTES  (BIG_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .link       (link),
        .cfg_addr4  (cfg_addr4),
        .cfg_bigbuf (cfg_bigbuf),
        .rd_data    (rd_data),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .io_out     (io_out),
        .io_oe      (io_oe),
        .wel        (wel),
        .ovf        (ovf)
    );

    qspi_tgt_mem #(
        .MEM_AW (MEM_AW)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rd_data)
    );

endmodule

// File: tb/tb_qspi_tgt.sv
module tb_qspi_tgt;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] io_in = 4'h0;
    logic [3:0] io_out;
    logic       io_oe;
    logic       cfg_addr4 = 1'b0;
    logic       cfg_bigbuf = 1'b0;
    logic       wel;
    logic       ovf;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];
    logic [7:0] pbuf [600];

    always #5 clk = ~clk;

    qspi_tgt dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .cfg_addr4(cfg_addr4),
        .cfg_bigbuf(cfg_bigbuf), .wel(wel), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_xfer();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_xfer();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic tick(input logic [3:0] n, output logic [3:0] got);
        io_in = n;
        wait_clk(4);
        got = io_out;
        sck = 1'b1;
        wait_clk(4);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic [3:0] g;
        tick(b[7:4], g);
        tick(b[3:0], g);
    endtask

    task automatic send_addr(input logic [31:0] a, input int nn);
        logic [3:0] g;
        for (int i = nn - 1; i >= 0; i--) begin
            tick(a[i*4 +: 4], g);
        end
    endtask

    task automatic wren();
        begin_xfer();
        send_byte(8'h06);
        end_xfer();
    endtask

    // program n bytes from pbuf; model updated up to lim bytes when accepted
    task automatic prog(input logic [7:0] op, input logic [31:0] a, input int nn,
                        input int n, input bit accept, input int lim);
        begin_xfer();
        send_byte(op);
        send_addr(a, nn);
        for (int i = 0; i < n; i++) begin
            send_byte(pbuf[i]);
            if (accept && i < lim) model[(a + i) % DEPTH] = model[(a + i) % DEPTH] & pbuf[i];
        end
        end_xfer();
    endtask

    task automatic rd(input logic [7:0] op, input logic [31:0] a, input int nn,
                      input int n, input string req);
        logic [3:0] h;
        logic [3:0] l;
        logic [7:0] e;
        begin_xfer();
        send_byte(op);
        send_addr(a, nn);
        chk(io_oe === 1'b1, "R7 io_oe in read", int'(io_oe), 1);
        for (int i = 0; i < n; i++) begin
            tick(4'h0, h);
            tick(4'h0, l);
            e = model[(a + i) % DEPTH];
            chk({h, l} === e, req, int'({h, l}), int'(e));
        end
        end_xfer();
    endtask

    initial begin
        wait_clk(200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] g;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);

        // R1 reset state
        chk(io_oe === 1'b0, "R1 io_oe", int'(io_oe), 0);
        chk(wel === 1'b0, "R1 wel", int'(wel), 0);
        chk(ovf === 1'b0, "R1 ovf", int'(ovf), 0);
        rd(8'hEB, 32'h0, 6, DEPTH, "R1 erased read");

        // R4 program ignored without latch
        for (int i = 0; i < 8; i++) pbuf[i] = 8'h00;
        prog(8'h02, 32'h000004, 6, 5, 1'b0, 0);
        rd(8'hEB, 32'h000004, 6, 5, "R4 ignored program");

        // R2 latch set, R5 consecutive program, R10 latch cleared
        wren();
        chk(wel === 1'b1, "R2 wel set", int'(wel), 1);
        pbuf[0] = 8'hA5; pbuf[1] = 8'h3C; pbuf[2] = 8'h0F; pbuf[3] = 8'hF0;
        prog(8'h02, 32'h000010, 6, 4, 1'b1, 256);
        chk(wel === 1'b0, "R10 wel cleared", int'(wel), 0);
        rd(8'hEB, 32'h000010, 6, 4, "R5 program data");

        // R5 AND rule over existing content
        wren();
        for (int i = 0; i < 4; i++) pbuf[i] = 8'hF0 ^ 8'(i * 8'h11);
        prog(8'h02, 32'h000010, 6, 4, 1'b1, 256);
        rd(8'hEB, 32'h000010, 6, 4, "R5 AND result");

        // R3 address length variants
        cfg_addr4 = 1'b1;
        wren();
        for (int i = 0; i < 4; i++) pbuf[i] = 8'(8'h81 + i);
        prog(8'h02, 32'h00000020, 8, 4, 1'b1, 256);
        rd(8'h0C, 32'h00000020, 8, 4, "R3 4-byte 0x02/0x0C");
        rd(8'hEB, 32'h00000020, 8, 4, "R3 4-byte 0xEB");
        cfg_addr4 = 1'b0;
        wren();
        for (int i = 0; i < 4; i++) pbuf[i] = 8'(8'h42 + i);
        prog(8'h12, 32'h00000030, 8, 4, 1'b1, 256);
        rd(8'hEC, 32'h00000030, 8, 4, "R3 0x12 and 0xEC");
        rd(8'hEB, 32'h000030, 6, 4, "R3 3-byte 0xEB");

        // R8 wrap on read
        rd(8'hEB, 32'h00003E, 6, 6, "R8 wrap");

        // R6 page limit
        wren();
        for (int i = 0; i < 256; i++) pbuf[i] = 8'hFF;
        pbuf[256] = 8'h00;
        prog(8'h02, 32'h000008, 6, 257, 1'b1, 256);
        chk(ovf === 1'b1, "R6 ovf set", int'(ovf), 1);
        rd(8'hEB, 32'h000008, 6, 1, "R6 dropped byte");
        cfg_bigbuf = 1'b1;
        wren();
        prog(8'h02, 32'h000008, 6, 257, 1'b1, 512);
        chk(ovf === 1'b0, "R6 ovf clear big", int'(ovf), 0);
        rd(8'hEB, 32'h000008, 6, 1, "R6 big buffer byte");
        cfg_bigbuf = 1'b0;

        // R9 abort mid data byte
        wren();
        begin_xfer();
        send_byte(8'h02);
        send_addr(32'h000028, 6);
        send_byte(8'h00);
        tick(4'h0, g);
        end_xfer();
        model[8'h28] = 8'h00;
        chk(wel === 1'b0, "R10 wel after abort", int'(wel), 0);
        rd(8'hEB, 32'h000028, 6, 2, "R9 partial byte dropped");

        // R9 abort mid opcode then fresh command
        begin_xfer();
        tick(4'h0, g);
        end_xfer();
        wren();
        chk(wel === 1'b1, "R9 fresh opcode", int'(wel), 1);

        // R11 unknown opcode
        begin_xfer();
        send_byte(8'hAB);
        send_addr(32'h000000, 6);
        send_byte(8'h00);
        chk(io_oe === 1'b0, "R11 no drive", int'(io_oe), 0);
        end_xfer();
        chk(wel === 1'b1, "R11 wel kept", int'(wel), 1);
        rd(8'hEB, 32'h000000, 6, DEPTH, "R11 memory intact");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule